// File: doc/BRIEF.md
# NaN classify and quieting unit

This unit looks at one IEEE 754 single-precision operand and reports which of six classes it belongs to: zero, denormal, normal, infinity, quiet NaN or signaling NaN. When the operand is a signaling NaN it also produces the quieted form of that NaN and raises an invalid-operation flag. Every other operand leaves the unit unchanged, and the flag stays low.

A mode input selects how the most significant fraction bit (bit 22) is read. With the 2008 convention, a NaN that has this bit set is quiet. With the legacy convention, the same bit marks a signaling NaN. Quieting follows the selected convention. In 2008 mode the unit sets bit 22. In legacy mode it clears bit 22, and if that leaves the fraction empty it sets fraction bit 21, so that the result is never mistaken for infinity.

The datapath is purely combinational. A parameter adds one output register stage with an asynchronous reset, for use when the unit sits on a timing-critical path.

Top module: `fp_nan_guard`

## Requirements
- R1: With the output register present, while reset is asserted and in the first cycle after it, `res_out` is zero, `class_out` is zero and `invalid_out` is low.
- R2: `class_out` has exactly one bit set for every operand. The bit positions are: bit 0 zero, bit 1 denormal, bit 2 normal, bit 3 infinity, bit 4 quiet NaN, bit 5 signaling NaN.
- R3: An operand whose exponent field is all ones and whose fraction is nonzero is a NaN. It is signaling when bit 22 is clear and `mode_2008` is 1, or when bit 22 is set and `mode_2008` is 0. Otherwise it is quiet.
- R4: `invalid_out` is high exactly when the operand is a signaling NaN.
- R5: Any operand that is not a signaling NaN appears on `res_out` bit for bit.
- R6: In 2008 mode, the result for a signaling NaN equals the operand with bit 22 set.
- R7: In legacy mode, the result for a signaling NaN equals the operand with bit 22 cleared. If the fraction is then zero, fraction bit 21 is also set.
- R8: Quieting never alters the sign bit or the exponent field, and the result is always a NaN.
- R9: With the output register present, the outputs follow the inputs after exactly one rising clock edge and hold steady between edges.
- R10: An all-ones exponent with a zero fraction is classed as infinity in both modes, raises no flag and passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_2008 | input | 1 | 1 selects the 2008 NaN convention, 0 selects the legacy convention |
| op_in | input | 32 | Single-precision operand |
| res_out | output | 32 | Quieted NaN, or the operand unchanged |
| class_out | output | 6 | One-hot class of the operand |
| invalid_out | output | 1 | Invalid-operation flag |

## Verification
The hardest case to reach is a legacy-mode signaling NaN whose only set fraction bit is bit 22. Clearing that bit alone would yield infinity, so only this operand exercises the fallback to bit 21. The bench applies the operand 0x7FC00000 with the mode input low and expects 0x7FA00000. It also applies the same bit pattern in 2008 mode, where the operand is quiet and must pass through unchanged. This shows that the same bits give opposite decisions depending on the mode.

// File: rtl/fp_nan_pkg.sv
package fp_nan_pkg;
   // one-hot class positions
   localparam int CLS_W      = 6;
   localparam int CLS_ZERO   = 0;
   localparam int CLS_DENORM = 1;
   localparam int CLS_NORMAL = 2;
   localparam int CLS_INF    = 3;
   localparam int CLS_QNAN   = 4;
   localparam int CLS_SNAN   = 5;

   typedef logic [CLS_W-1:0] fp_cls_t;
endpackage

// File: rtl/fp_field_split.sv
module fp_field_split #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [EXP_W+FRAC_W:0] op,
   output logic                  exp_ones,
   output logic                  exp_zero,
   output logic                  frac_zero,
   output logic                  quiet_bit
);
   localparam int Q_POS = FRAC_W - 1;

   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac_f;

   always_comb begin
      exp_f     = op[EXP_W+FRAC_W-1:FRAC_W];
      frac_f    = op[FRAC_W-1:0];
      exp_ones  = &exp_f;
      exp_zero  = ~|exp_f;
      frac_zero = ~|frac_f;
      quiet_bit = frac_f[Q_POS];
   end
endmodule

// File: rtl/fp_class_decode.sv
module fp_class_decode
   import fp_nan_pkg::*;
(
   input  logic    exp_ones,
   input  logic    exp_zero,
   input  logic    frac_zero,
   input  logic    quiet_bit,
   input  logic    mode_2008,
   output fp_cls_t cls,
   output logic    is_snan
);
   logic is_nan;

   always_comb begin
      is_nan  = exp_ones & ~frac_zero;
      // 2008: indicator clear means signaling; legacy: indicator set means signaling
      is_snan = is_nan & (quiet_bit ^ mode_2008);
      cls                = '0;
      cls[CLS_ZERO]      = exp_zero & frac_zero;
      cls[CLS_DENORM]    = exp_zero & ~frac_zero;
      cls[CLS_NORMAL]    = ~exp_zero & ~exp_ones;
      cls[CLS_INF]       = exp_ones & frac_zero;
      cls[CLS_QNAN]      = is_nan & ~is_snan;
      cls[CLS_SNAN]      = is_snan;
   end
endmodule

// File: rtl/fp_nan_quieter.sv
module fp_nan_quieter #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [EXP_W+FRAC_W:0] op,
   input  logic                  is_snan,
   input  logic                  mode_2008,
   output logic [EXP_W+FRAC_W:0] res,
   output logic                  invalid
);
   localparam int Q_POS  = FRAC_W - 1;
   localparam int FB_POS = FRAC_W - 2;

   logic [FRAC_W-1:0] frac_f;
   logic [FRAC_W-1:0] frac_new;
   logic [FRAC_W-1:0] frac_clr;

   always_comb begin
      frac_f   = op[FRAC_W-1:0];
      frac_clr = frac_f;
      frac_clr[Q_POS] = 1'b0;
      if (mode_2008) begin
         frac_new        = frac_f;
         frac_new[Q_POS] = 1'b1;
      end else begin
         frac_new = frac_clr;
         // stop the cleared pattern from reading as infinity
         if (~|frac_clr) frac_new[FB_POS] = 1'b1;
      end
      res     = is_snan ? {op[EXP_W+FRAC_W:FRAC_W], frac_new} : op;
      invalid = is_snan;
   end
endmodule

// File: rtl/fp_nan_guard.sv
module fp_nan_guard
   import fp_nan_pkg::*;
#(
   parameter int EXP_W   = 8,
   parameter int FRAC_W  = 23,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  mode_2008,
   input  logic [EXP_W+FRAC_W:0] op_in,
   output logic [EXP_W+FRAC_W:0] res_out,
   output logic [CLS_W-1:0]      class_out,
   output logic                  invalid_out
);
   localparam int W = 1 + EXP_W + FRAC_W;

   if (FRAC_W < 2) begin : g_bad_frac
      $error("fp_nan_guard: FRAC_W must be at least 2");
   end
   if (EXP_W < 2) begin : g_bad_exp
      $error("fp_nan_guard: EXP_W must be at least 2");
   end

   logic         exp_ones, exp_zero, frac_zero, quiet_bit;
   logic         snan_c, inv_c;
   fp_cls_t      cls_c;
   logic [W-1:0] res_c;

   fp_field_split #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_split (
      .op(op_in), .exp_ones(exp_ones), .exp_zero(exp_zero),
      .frac_zero(frac_zero), .quiet_bit(quiet_bit)
   );

   fp_class_decode u_cls (
      .exp_ones(exp_ones), .exp_zero(exp_zero), .frac_zero(frac_zero),
      .quiet_bit(quiet_bit), .mode_2008(mode_2008),
      .cls(cls_c), .is_snan(snan_c)
   );

   fp_nan_quieter #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_quiet (
      .op(op_in), .is_snan(snan_c), .mode_2008(mode_2008),
      .res(res_c), .invalid(inv_c)
   );

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            res_out     <= '0;
            class_out   <= '0;
            invalid_out <= 1'b0;
         end else begin
            res_out     <= res_c;
            class_out   <= cls_c;
            invalid_out <= inv_c;
         end
      end
      // R9: one-cycle latency
      a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (class_out == $past(cls_c) && res_out == $past(res_c)
                   && invalid_out == $past(inv_c)));
   end else begin : g_comb
      always_comb begin
         res_out     = res_c;
         class_out   = cls_c;
         invalid_out = inv_c;
      end
   end

   // R2: exactly one class
   a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(cls_c) == 1);
   // R4: flag tracks the signaling class
   a_r4_flag: assert property (@(posedge clk) disable iff (!rst_n)
      inv_c == cls_c[CLS_SNAN]);
   // R5: non-signaling operands pass through
   a_r5_pass: assert property (@(posedge clk) disable iff (!rst_n)
      !inv_c |-> res_c == op_in);
   // R8: sign and exponent kept, result is a NaN
   a_r8_keep_hi: assert property (@(posedge clk) disable iff (!rst_n)
      res_c[W-1:FRAC_W] == op_in[W-1:FRAC_W]);
   a_r8_still_nan: assert property (@(posedge clk) disable iff (!rst_n)
      inv_c |-> (&res_c[W-2:FRAC_W]) && (|res_c[FRAC_W-1:0]));
endmodule

// File: tb/test_fp_nan_guard.sv
module test_fp_nan_guard;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_2008 = 1'b1;
   logic [31:0] op_in = 32'h0;
   logic [31:0] res_out;
   logic [5:0]  class_out;
   logic        invalid_out;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fp_nan_guard i_fp_nan_guard (
      .clk(clk), .rst_n(rst_n), .mode_2008(mode_2008), .op_in(op_in),
      .res_out(res_out), .class_out(class_out), .invalid_out(invalid_out)
   );

   task automatic chk(input string req, input logic [31:0] e_res,
                      input logic [5:0] e_cls, input logic e_inv);
      checks++;
      if (res_out !== e_res || class_out !== e_cls || invalid_out !== e_inv) begin
         errors++;
         $display("FAIL %s: res=%h cls=%b inv=%b expected res=%h cls=%b inv=%b",
                  req, res_out, class_out, invalid_out, e_res, e_cls, e_inv);
      end
   endtask

   task automatic apply(input logic [31:0] op, input logic m);
      @(negedge clk);
      op_in     = op;
      mode_2008 = m;
      @(negedge clk);
   endtask

   task automatic t_reset;
      #1 chk("R1 during reset", 32'h0, 6'b0, 1'b0);
      @(negedge clk);
      op_in = 32'h7F800001;
      rst_n = 1'b1;
      #1 chk("R1 after release", 32'h0, 6'b0, 1'b0);
   endtask

   task automatic t_plain;
      apply(32'h00000000, 1'b1); chk("R2 R5 +zero",   32'h00000000, 6'b000001, 1'b0);
      apply(32'h80000000, 1'b0); chk("R2 R5 -zero",   32'h80000000, 6'b000001, 1'b0);
      apply(32'h00000001, 1'b1); chk("R2 R5 denorm",  32'h00000001, 6'b000010, 1'b0);
      apply(32'h3F800000, 1'b0); chk("R2 R5 normal",  32'h3F800000, 6'b000100, 1'b0);
   endtask

   task automatic t_inf;
      apply(32'h7F800000, 1'b1); chk("R10 +inf 2008",   32'h7F800000, 6'b001000, 1'b0);
      apply(32'hFF800000, 1'b0); chk("R10 -inf legacy", 32'hFF800000, 6'b001000, 1'b0);
   endtask

   task automatic t_mode2008;
      apply(32'h7FC00000, 1'b1); chk("R3 R5 2008 qnan", 32'h7FC00000, 6'b010000, 1'b0);
      apply(32'h7F800001, 1'b1); chk("R4 R6 2008 snan", 32'h7FC00001, 6'b100000, 1'b1);
      apply(32'hFFA00000, 1'b1); chk("R6 R8 2008 neg snan", 32'hFFE00000, 6'b100000, 1'b1);
   endtask

   task automatic t_legacy;
      apply(32'h7FC00000, 1'b0); chk("R7 legacy bit22 only", 32'h7FA00000, 6'b100000, 1'b1);
      apply(32'h7FC00005, 1'b0); chk("R7 legacy snan", 32'h7F800005, 6'b100000, 1'b1);
      apply(32'hFFE00000, 1'b0); chk("R7 R8 legacy neg snan", 32'hFFA00000, 6'b100000, 1'b1);
      apply(32'h7F800001, 1'b0); chk("R3 legacy qnan", 32'h7F800001, 6'b010000, 1'b0);
   endtask

   task automatic t_latency;
      apply(32'h3F800000, 1'b1);
      op_in = 32'h7F800001;
      #1 chk("R9 holds before edge", 32'h3F800000, 6'b000100, 1'b0);
      @(negedge clk);
      chk("R9 updates after edge", 32'h7FC00001, 6'b100000, 1'b1);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_plain();
      t_inf();
      t_mode2008();
      t_legacy();
      t_latency();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule